// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

This block counts the rising edges of a monitored clock during a time window whose length is given in cycles of a reference clock. Software programs a 20-bit window length, sets a start bit, and later reads the edge count from a read-only result register. The ratio of the result to the window length gives the monitored frequency relative to the reference.

The window is opened by a down-counter in the reference domain. The open level crosses into the monitored domain through a two-flop synchroniser, where a counter runs while it is high. The monitored side echoes the level back as an acknowledge, which is synchronised into the reference domain. The reference side waits for that acknowledge to rise before closing the window and for it to fall before capturing the count. The window therefore cannot be missed, and the captured count has settled before it is read.

Register access is a single-cycle write strobe with a shared word address. Read data is registered and appears one reference cycle after the address.

Top module: `freq_meter`

## Requirements
- R1: After reset, the control word (address 0), the window-length word (address 1) and the result word (address 2) all read 0.
- R2: The window length is held in bits 19:0 of address 1. It is readable and writable, and bits 31:20 always read 0.
- R3: Writing 1 to control bit 0 while idle, with a nonzero length, starts a measurement. Control bit 0 reads 1 while it runs. The window stays open for at least the programmed number of reference cycles. Control bit 0 returns to 0 by itself when the measurement ends.
- R4: The result (bits 23:0 of address 2) equals the number of monitored rising edges seen while the window was open. It lies within 3 of (length+1) times the ratio of the monitored frequency to the reference frequency.
- R5: Control bit 1 is the completion flag. It is set when a result becomes valid. Writing 1 to bit 1 clears it, and writing 0 to it leaves it unchanged.
- R6: Starting with a window length of 0 ends the measurement at once. The completion flag is set on the second reference cycle after the start write, and the result reads 0.
- R7: A start write made while a measurement is in progress is ignored. The running window neither restarts nor lengthens.
- R8: Starting a new measurement clears the completion flag.
- R9: Writes to the result address do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; the window length is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset; resynchronised for the monitored domain |
| mon_clk | input | 1 | Clock whose rising edges are counted |
| bus_we | input | 1 | Register write strobe, sampled on ref_clk |
| bus_addr | input | 2 | Word address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
A down-counter that loads or decrements wrongly shows up at the ports as a wrong completion time: the completion flag rises a number of reference cycles that differs from the programmed length. Polling control bit 1 reveals this within the window plus a few synchroniser cycles. A broken handshake or edge counter shows up as a result outside the ±3 band for the chosen clock ratios. A lost acknowledge shows up as a busy bit that never clears. Errors in the flag and start logic show up on the very next control read after the offending write.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} fm_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LEN  = 2'd1;
  localparam logic [1:0] ADDR_RES  = 2'd2;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_DONE_BIT = 1;
endpackage

// File: rtl/fm_sync.sv
`timescale 1ns/1ps
module fm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fm_window.sv
`timescale 1ns/1ps
module fm_window
  import fm_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic             ack_s,
  output logic             win,
  output logic             busy,
  output logic             fin,
  output logic             take,
  output logic [LEN_W-1:0] dcnt
);
  fm_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      dcnt  <= '0;
      win   <= 1'b0;
      fin   <= 1'b0;
      take  <= 1'b0;
    end else begin
      fin  <= 1'b0;
      take <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (go) begin
            if (len == '0) begin
              fin <= 1'b1;
            end else begin
              dcnt  <= len;
              win   <= 1'b1;
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (dcnt != '0) begin
            dcnt <= dcnt - 1'b1;
          end else if (ack_s) begin
            win   <= 1'b0;
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!ack_s) begin
            fin   <= 1'b1;
            take  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/1ps
module fm_edge_counter #(
  parameter int CNT_W = 24
) (
  input  logic             mon_clk,
  input  logic             mon_rst,
  input  logic             win,
  output logic [CNT_W-1:0] cnt,
  output logic             ack
);
  logic win_m;

  fm_sync #(.W(1), .STAGES(2)) u_win_sync (
    .clk(mon_clk), .rst(mon_rst), .d(win), .q(win_m)
  );

  always_ff @(posedge mon_clk) begin
    if (mon_rst) begin
      cnt <= '0;
      ack <= 1'b0;
    end else begin
      ack <= win_m;
      if (win_m) cnt <= ack ? cnt + 1'b1 : CNT_W'(1);
    end
  end
endmodule

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter
  import fm_pkg::*;
#(
  parameter int LEN_W  = 20,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              ref_clk,
  input  logic              rst,
  input  logic              mon_clk,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] result_q;
  logic             done_q;
  logic             busy, win, fin, take, ack_s, mon_ack, mon_rst;
  logic [LEN_W-1:0] dcnt;
  logic [CNT_W-1:0] mon_cnt;
  logic             ctrl_wr, go;

  assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
  assign go      = ctrl_wr && bus_wdata[CTRL_GO_BIT] && !busy;

  fm_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(mon_clk), .rst(1'b0), .d(rst), .q(mon_rst)
  );

  fm_sync #(.W(1), .STAGES(2)) u_ack_sync (
    .clk(ref_clk), .rst(rst), .d(mon_ack), .q(ack_s)
  );

  fm_window #(.LEN_W(LEN_W)) u_window (
    .clk(ref_clk), .rst(rst), .go(go), .len(len_q), .ack_s(ack_s),
    .win(win), .busy(busy), .fin(fin), .take(take), .dcnt(dcnt)
  );

  fm_edge_counter #(.CNT_W(CNT_W)) u_counter (
    .mon_clk(mon_clk), .mon_rst(mon_rst), .win(win),
    .cnt(mon_cnt), .ack(mon_ack)
  );

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      len_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (bus_we && bus_addr == ADDR_LEN) len_q <= bus_wdata[LEN_W-1:0];
      if (take) result_q <= mon_cnt;
      else if (go && len_q == '0) result_q <= '0;
      if (fin) done_q <= 1'b1;
      else if (go) done_q <= 1'b0;
      else if (ctrl_wr && bus_wdata[CTRL_DONE_BIT]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_CTRL: bus_rdata <= DATA_W'({done_q, busy});
        ADDR_LEN:  bus_rdata <= DATA_W'(len_q);
        ADDR_RES:  bus_rdata <= DATA_W'(result_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fm_checker.sv
`timescale 1ns/1ps
module fm_checker
  import fm_pkg::*;
#(
  parameter int LEN_W  = 20,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              we,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              busy,
  input logic              done,
  input logic              fin,
  input logic [LEN_W-1:0]  dcnt,
  input logic [LEN_W-1:0]  len,
  input logic [CNT_W-1:0]  result
);
  a_r2_len_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_LEN) |-> (rdata[DATA_W-1:LEN_W] == '0));

  a_r3_end_sets_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> done);

  a_r5_done_w1c: assert property (@(posedge clk) disable iff (rst)
    (done && !fin && we && addr == ADDR_CTRL && wdata[CTRL_DONE_BIT]) |=> !done);

  a_r6_zero_len: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_CTRL && wdata[CTRL_GO_BIT] && !busy && len == '0)
      |=> (result == '0) ##1 done);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && dcnt != '0 && we && addr == ADDR_CTRL && wdata[CTRL_GO_BIT])
      |=> (dcnt == $past(dcnt) - 1'b1));
endmodule

bind freq_meter fm_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(ref_clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
  .rdata(bus_rdata), .busy(busy), .done(done_q), .fin(fin), .dcnt(dcnt),
  .len(len_q), .result(result_q)
);

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
  logic        ref_clk = 1'b0;
  logic        mon_clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  real         mon_half = 1.5;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    int          tol;
    string       tag;
    logic [1:0]  addr;
  } item_t;

  item_t sb_q[$];
  event  smp;

  freq_meter uut (
    .ref_clk(ref_clk), .rst(rst), .mon_clk(mon_clk), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2 ref_clk = ~ref_clk;
  initial forever #(mon_half) mon_clk = ~mon_clk;

  // monitor: pops expected items and compares against the sampled read data
  initial forever begin
    @(smp);
    if (sb_q.size() > 0) begin
      item_t it;
      int diff;
      it = sb_q.pop_front();
      diff = int'(bus_rdata) - int'(it.exp);
      if (diff < 0) diff = -diff;
      checks++;
      if (diff > it.tol) begin
        errors++;
        $display("FAIL %s addr=%0d actual=0x%08h expected=0x%08h tol=%0d",
                 it.tag, it.addr, bus_rdata, it.exp, it.tol);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge ref_clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge ref_clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] e,
                           input int tol, input string tag);
    item_t it;
    @(negedge ref_clk);
    bus_addr = a;
    it.exp = e; it.tol = tol; it.tag = tag; it.addr = a;
    sb_q.push_back(it);
    @(negedge ref_clk);
    -> smp;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(negedge ref_clk);
    bus_addr = a;
    @(negedge ref_clk);
    v = bus_rdata;
  endtask

  task automatic fail_direct(input string tag, input int act, input int e);
    checks++;
    errors++;
    $display("FAIL %s actual=%0d expected=%0d", tag, act, e);
  endtask

  // polls control until the completion flag rises; returns cycles elapsed
  task automatic wait_done(input int limit, output int cyc);
    logic [31:0] v;
    cyc = 0;
    v = '0;
    while (!v[1] && cyc < limit) begin
      peek(2'd0, v);
      cyc += 2;
    end
  endtask

  task automatic measure(input int len, input real half, input string tag);
    int cyc;
    int e;
    mon_half = half;
    repeat (10) @(negedge ref_clk);
    wr(2'd1, 32'(len));
    wr(2'd0, 32'h1);
    expect_rd(2'd0, 32'h1, 0, "R3 busy while running");
    wait_done(len + 200, cyc);
    checks++;
    if (cyc + 3 < len || cyc > len + 60) begin
      errors++;
      $display("FAIL R3 %s completion cycles actual=%0d expected=%0d..%0d",
               tag, cyc, len, len + 60);
    end
    expect_rd(2'd0, 32'h2, 0, "R3 R5 start cleared, done set");
    e = int'((len + 1) * 4.0 / (2.0 * half));
    expect_rd(2'd2, 32'(e), 3, tag);
  endtask

  initial begin
    int cyc;
    repeat (10) @(negedge ref_clk);
    rst = 1'b0;

    // R1 reset state
    expect_rd(2'd0, 32'h0, 0, "R1 ctrl");
    expect_rd(2'd1, 32'h0, 0, "R1 len");
    expect_rd(2'd2, 32'h0, 0, "R1 result");

    // R2 length field width and readback
    wr(2'd1, 32'hFFFF_FFFF);
    expect_rd(2'd1, 32'h000F_FFFF, 0, "R2 upper bits zero");
    wr(2'd1, 32'h0001_2345);
    expect_rd(2'd1, 32'h0001_2345, 0, "R2 readback");

    // R4 several clock ratios
    measure(200, 1.5, "R4 fast monitored clock");
    measure(200, 3.5, "R4 slower monitored clock");
    measure(300, 5.0, "R4 slowest monitored clock");

    // R5 write 0 keeps flag, write 1 clears it
    wr(2'd0, 32'h0);
    expect_rd(2'd0, 32'h2, 0, "R5 write 0 keeps flag");
    wr(2'd0, 32'h2);
    expect_rd(2'd0, 32'h0, 0, "R5 write 1 clears flag");

    // R9 result is read-only (current result from the last measurement)
    wr(2'd2, 32'h00FF_FFFF);
    expect_rd(2'd2, 32'(int'(301 * 4.0 / 10.0)), 3, "R9 result unchanged");

    // R8 start clears a pending completion flag
    mon_half = 2.0;
    wr(2'd1, 32'd100);
    wr(2'd0, 32'h1);
    wait_done(400, cyc);
    expect_rd(2'd0, 32'h2, 0, "R8 precondition done");
    wr(2'd0, 32'h1);
    expect_rd(2'd0, 32'h1, 0, "R8 done cleared by start");
    wait_done(400, cyc);

    // R6 zero length: flag on the second cycle, result 0
    wr(2'd1, 32'd0);
    @(negedge ref_clk);
    bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h1;
    @(negedge ref_clk);
    bus_we = 1'b0; bus_wdata = '0; bus_addr = 2'd0;
    @(negedge ref_clk);
    checks++;
    if (bus_rdata[1] !== 1'b0) begin
      errors++;
      $display("FAIL R6 flag too early actual=%0d expected=0", bus_rdata[1]);
    end
    @(negedge ref_clk);
    checks++;
    if (bus_rdata[1:0] !== 2'b10) begin
      errors++;
      $display("FAIL R6 ctrl actual=%0d expected=2", bus_rdata[1:0]);
    end
    expect_rd(2'd2, 32'h0, 0, "R6 result zero");

    // R7 start while busy is ignored
    mon_half = 3.5;
    wr(2'd1, 32'd400);
    wr(2'd0, 32'h1);
    repeat (150) @(negedge ref_clk);
    wr(2'd0, 32'h1);
    wait_done(800, cyc);
    cyc += 152;
    checks++;
    if (cyc > 400 + 60 || cyc + 3 < 400)
      begin errors++; $display("FAIL R7 completion cycles actual=%0d expected=400..460", cyc); end
    expect_rd(2'd2, 32'(int'(401 * 4.0 / 7.0)), 3, "R7 single window count");

    repeat (4) @(negedge ref_clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!finished) begin
      finished = 1;
      fail_direct("watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule